// File: doc/BRIEF.md
# Write-Protect Fault-Suppressing Opcode Decoder

This decoder stage sits in front of the execute logic of a small cell processor. The cell may read the registers of neighbouring cells but may not write them. For every instruction the stage takes the destination register field and decides whether that register may be written. It then places one extra "ghost" bit above the opcode, which gives a wider effective opcode. An instruction that would write a read-only register therefore becomes a distinct code, and every such code decodes as the UNASSIGNED operation.

UNASSIGNED pauses the cell for that one instruction and never raises a fault. The stage drops the register-file write enable in the same cycle, so no partial write can take place. After the pause the cell moves on to the next instruction as usual. All outputs are registered, so decode results appear one clock after a valid instruction is presented.

Instruction word layout, with the default parameters (11 bits): opcode in bits [10:8], source register in bits [7:4], destination register in bits [3:0]. A register code whose most significant bit is 1 names an external, read-only neighbour register. For example, 4'b1011 is the read-only twin of the internal register 4'b0011. With the default destination mask, opcodes 3'b000, 3'b001 and 3'b010 have no destination, and opcodes 3'b011 through 3'b111 write their destination. The register move opcode is 3'b100.

Top module: `ghost_decoder`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `dec_valid`, `rf_we` and `pause` are 0.
- R2: `dec_valid` is 1 in exactly the cycle after a cycle in which `instr_valid` was 1, giving one cycle of latency.
- R3: `eff_opcode[2:0]` equals the opcode field (bits [10:8]) of the instruction that was decoded, and `eff_opcode[3]` is the ghost bit.
- R4: For an opcode that has a destination, the ghost bit is 1 exactly when bit 3 of the destination field (instruction bit 3) is 1, which marks an external register.
- R5: For an opcode with no destination (3'b000, 3'b001, 3'b010), the ghost bit is 0 and `rf_we` is 0, whatever the destination field holds.
- R6: When the ghost bit is 1, `dec_op` is UNASSIGNED (4'b1000), `pause` is 1 and `rf_we` is 0, all in the same output cycle.
- R7: When the ghost bit is 0, `dec_op` is the opcode zero-extended to 4 bits, `pause` is 0, and `rf_we` is 1 exactly when the opcode has a destination.
- R8: A pause lasts only one cycle. A writable instruction that follows a paused one decodes normally, with `pause` 0.
- R9: In a cycle where `dec_valid` is 0, both `rf_we` and `pause` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 11 | Instruction: opcode, source register, destination register |
| dec_valid | output | 1 | Decode outputs are valid |
| eff_opcode | output | 4 | Ghost bit followed by the 3-bit opcode |
| dec_op | output | 4 | Decoded operation; 4'b1000 is UNASSIGNED |
| rf_we | output | 1 | Register-file write enable |
| pause | output | 1 | Cell pauses for this instruction |

## Verification
In one output cycle the opcode decode can ask for a register write while the ghost remap asks for a pause. A move or arithmetic opcode aimed at an external destination provokes exactly this collision. The bench sends such instructions back to back with the same opcodes aimed at internal registers. For each one it checks that the pause wins outright: write enable is low, the operation is UNASSIGNED, and the very next writable instruction writes with no leftover pause. Opcodes with no destination, carrying external-looking destination fields, show that the ghost bit is not derived from that field alone.

// File: rtl/ghost_dec_pkg.sv
package ghost_dec_pkg;
   // Default field widths
   localparam int DEF_OPC_W = 3;
   localparam int DEF_REG_W = 4;
   // Bit n set: opcode n writes its destination register
   localparam logic [7:0] DEF_DEST_MASK = 8'b1111_1000;
   // Named base opcodes of the default encoding
   localparam logic [2:0] OPC_IDLE = 3'b000;
   localparam logic [2:0] OPC_MARK = 3'b001;
   localparam logic [2:0] OPC_JUMP = 3'b010;
   localparam logic [2:0] OPC_ADD  = 3'b011;
   localparam logic [2:0] OPC_MOVE = 3'b100;
   localparam logic [2:0] OPC_AND  = 3'b101;
   localparam logic [2:0] OPC_XOR  = 3'b110;
   localparam logic [2:0] OPC_INC  = 3'b111;
endpackage

// File: rtl/ghost_dest_probe.sv
module ghost_dest_probe #(
   parameter int OPC_W = ghost_dec_pkg::DEF_OPC_W,
   parameter int REG_W = ghost_dec_pkg::DEF_REG_W,
   parameter logic [(1<<OPC_W)-1:0] DEST_MASK = ghost_dec_pkg::DEF_DEST_MASK,
   parameter bit EXT_WHEN_SET = 1'b1,
   localparam int INSTR_W = OPC_W + 2*REG_W
) (
   input  logic [INSTR_W-1:0] instr,
   output logic               has_dest,
   output logic               ghost
);
   logic [OPC_W-1:0] opc;
   logic [REG_W-1:0] dst;
   logic             dst_external;

   if (REG_W < 2) begin : g_bad_reg
      $error("ghost_dest_probe: REG_W must be at least 2");
   end

   assign opc      = instr[INSTR_W-1 -: OPC_W];
   assign dst      = instr[REG_W-1:0];
   assign has_dest = DEST_MASK[opc];

   // Polarity of the external-register marker is a build option
   if (EXT_WHEN_SET) begin : g_ext_high
      assign dst_external = dst[REG_W-1];
   end else begin : g_ext_low
      assign dst_external = ~dst[REG_W-1];
   end

   // Destination-free instructions never carry a ghost bit
   assign ghost = has_dest & dst_external;
endmodule

// File: rtl/ghost_op_map.sv
module ghost_op_map #(
   parameter int OPC_W = ghost_dec_pkg::DEF_OPC_W,
   localparam int EFF_W = OPC_W + 1
) (
   input  logic [EFF_W-1:0] eff_opcode,
   input  logic             has_dest,
   output logic [EFF_W-1:0] dec_op,
   output logic             we_raw,
   output logic             pause_raw
);
   localparam logic [EFF_W-1:0] UNASSIGNED = EFF_W'(1) << OPC_W;

   logic ghost;
   assign ghost = eff_opcode[EFF_W-1];

   always_comb begin
      if (ghost) begin
         dec_op    = UNASSIGNED;
         we_raw    = 1'b0;
         pause_raw = 1'b1;
      end else begin
         dec_op    = {1'b0, eff_opcode[OPC_W-1:0]};
         we_raw    = has_dest;
         pause_raw = 1'b0;
      end
   end

   always_comb begin
      assert_ghost_blocks_write_R6: assert (!(ghost && we_raw));
   end
endmodule

// File: rtl/ghost_out_reg.sv
module ghost_out_reg #(
   parameter int EFF_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [EFF_W-1:0] in_eff,
   input  logic [EFF_W-1:0] in_op,
   input  logic             in_we,
   input  logic             in_pause,
   output logic             q_valid,
   output logic [EFF_W-1:0] q_eff,
   output logic [EFF_W-1:0] q_op,
   output logic             q_we,
   output logic             q_pause
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_eff   <= '0;
         q_op    <= '0;
         q_we    <= 1'b0;
         q_pause <= 1'b0;
      end else begin
         q_valid <= in_valid;
         q_we    <= in_valid & in_we;
         q_pause <= in_valid & in_pause;
         if (in_valid) begin
            q_eff <= in_eff;
            q_op  <= in_op;
         end
      end
   end

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> q_valid);
   assert_idle_after_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !q_valid);
   assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !q_valid |-> (!q_we && !q_pause));
endmodule

// File: rtl/ghost_decoder.sv
module ghost_decoder #(
   parameter int OPC_W = ghost_dec_pkg::DEF_OPC_W,
   parameter int REG_W = ghost_dec_pkg::DEF_REG_W,
   parameter logic [(1<<OPC_W)-1:0] DEST_MASK = ghost_dec_pkg::DEF_DEST_MASK,
   parameter bit EXT_WHEN_SET = 1'b1,
   localparam int INSTR_W = OPC_W + 2*REG_W,
   localparam int EFF_W   = OPC_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr_word,
   output logic               dec_valid,
   output logic [EFF_W-1:0]   eff_opcode,
   output logic [EFF_W-1:0]   dec_op,
   output logic               rf_we,
   output logic               pause
);
   if (OPC_W < 1 || OPC_W > 6) begin : g_bad_opc
      $error("ghost_decoder: OPC_W out of range");
   end

   logic             has_dest;
   logic             ghost;
   logic [EFF_W-1:0] eff_c;
   logic [EFF_W-1:0] op_c;
   logic             we_c;
   logic             pause_c;

   ghost_dest_probe #(
      .OPC_W(OPC_W), .REG_W(REG_W), .DEST_MASK(DEST_MASK),
      .EXT_WHEN_SET(EXT_WHEN_SET)
   ) u_probe (
      .instr(instr_word), .has_dest(has_dest), .ghost(ghost)
   );

   // Ghost bit sits above the opcode MSB
   assign eff_c = {ghost, instr_word[INSTR_W-1 -: OPC_W]};

   ghost_op_map #(.OPC_W(OPC_W)) u_map (
      .eff_opcode(eff_c), .has_dest(has_dest),
      .dec_op(op_c), .we_raw(we_c), .pause_raw(pause_c)
   );

   ghost_out_reg #(.EFF_W(EFF_W)) u_oreg (
      .clk(clk), .rst_n(rst_n), .in_valid(instr_valid),
      .in_eff(eff_c), .in_op(op_c), .in_we(we_c), .in_pause(pause_c),
      .q_valid(dec_valid), .q_eff(eff_opcode), .q_op(dec_op),
      .q_we(rf_we), .q_pause(pause)
   );

   assert_pause_excludes_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pause |-> !rf_we);
   assert_ghost_means_unassigned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && eff_opcode[EFF_W-1]) |-> (pause && dec_op[EFF_W-1]));
   assert_opcode_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid |=> (eff_opcode[OPC_W-1:0] == $past(instr_word[INSTR_W-1 -: OPC_W])));
   assert_no_dest_no_ghost_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !DEST_MASK[instr_word[INSTR_W-1 -: OPC_W]]) |=>
         (!eff_opcode[EFF_W-1] && !rf_we));
   assert_clear_ghost_no_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !eff_opcode[EFF_W-1]) |-> (!pause && !dec_op[EFF_W-1]));
endmodule

// File: tb/test_ghost_decoder.sv
`timescale 1ns/1ps
module test_ghost_decoder;
   typedef struct {
      logic [3:0] eff;
      logic [3:0] op;
      logic       we;
      logic       pse;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [10:0] instr_word = '0;
   logic        dec_valid;
   logic [3:0]  eff_opcode;
   logic [3:0]  dec_op;
   logic        rf_we;
   logic        pause;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   exp_t sb[$];

   always #4 clk = ~clk;

   ghost_decoder i_ghost_decoder (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
      .dec_valid(dec_valid), .eff_opcode(eff_opcode), .dec_op(dec_op),
      .rf_we(rf_we), .pause(pause)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Driver: applies one instruction and pushes the expected result
   task automatic send(input logic [2:0] opc, input logic [3:0] src,
                       input logic [3:0] dst, input string tag);
      exp_t e;
      bit hasd;
      bit gh;
      @(negedge clk);
      hasd = (opc >= 3'b011);
      gh   = hasd && dst[3];
      e.eff = {gh, opc};
      e.op  = gh ? 4'b1000 : {1'b0, opc};
      e.we  = hasd && !gh;
      e.pse = gh;
      e.tag = tag;
      sb.push_back(e);
      instr_valid = 1'b1;
      instr_word  = {opc, src, dst};
   endtask

   task automatic gap();
      @(negedge clk);
      instr_valid = 1'b0;
      instr_word  = 11'h7FF;
   endtask

   // Monitor: samples 1 ns after each rising edge
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (dec_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R2", "unexpected dec_valid", 4'h1, 4'h0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(eff_opcode == e.eff, {e.tag, " R3 R4"}, "eff_opcode", eff_opcode, e.eff);
               check(dec_op == e.op, e.tag, "dec_op", dec_op, e.op);
               check(rf_we == e.we, e.tag, "rf_we", {3'b0, rf_we}, {3'b0, e.we});
               check(pause == e.pse, e.tag, "pause", {3'b0, pause}, {3'b0, e.pse});
            end
         end else begin
            check(!rf_we && !pause, "R9", "idle we/pause", {2'b0, rf_we, pause}, 4'h0);
            check(sb.size() == 0, "R2", "missing dec_valid", 4'h0, 4'h1);
         end
      end
   end

   initial begin
      // R1: reset state, including a valid instruction held during reset
      instr_valid = 1'b1;
      instr_word  = {3'b100, 4'h3, 4'hB};
      repeat (3) @(posedge clk);
      #1;
      check(!dec_valid && !rf_we && !pause, "R1", "reset outputs",
            {1'b0, dec_valid, rf_we, pause}, 4'h0);
      @(negedge clk);
      instr_valid = 1'b0;
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check(!dec_valid && !rf_we && !pause, "R1", "first cycle after reset",
            {1'b0, dec_valid, rf_we, pause}, 4'h0);

      // R7: writable destinations
      send(3'b100, 4'hB, 4'h3, "R7");
      send(3'b011, 4'h1, 4'h7, "R7");
      // R6: move into external register (write vs pause collide)
      send(3'b100, 4'h3, 4'hB, "R6");
      // R8: writable move right after the paused one
      send(3'b100, 4'h3, 4'h2, "R8");
      send(3'b111, 4'h0, 4'h8, "R6");
      send(3'b111, 4'h0, 4'h8, "R6");
      send(3'b101, 4'h9, 4'h1, "R8");
      gap();
      // R5: no-destination opcodes with external-looking destination fields
      send(3'b000, 4'hF, 4'hF, "R5");
      send(3'b001, 4'h0, 4'hC, "R5");
      send(3'b010, 4'h8, 4'h9, "R5");
      gap();
      gap();
      // R4: sweep all opcodes over all destinations
      for (int o = 0; o < 8; o++) begin
         for (int d = 0; d < 16; d++) begin
            send(3'(o), 4'(d ^ 5), 4'(d), "R4");
            if (d % 5 == 4) gap();
         end
      end
      gap();
      repeat (3) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (200000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule